// File: doc/BRIEF.md
# DMA Cycle Type Translator

This block sits behind the DMA grant logic of a PCI-to-ISA bridge. Once a legacy DMA channel has been granted, the PCI I/O accesses that follow are not ordinary I/O. Each one carries a DMA transfer for that channel. The block decodes the low address of each such access into a cycle kind and a terminal-count indication. It then emits a single-cycle ISA-side DMA command (read, write or verify) tagged with the granted channel. Accesses that do not match a DMA address are reported as unclaimed, so that another decoder can take them.

A grant is loaded with a one-cycle pulse on `gnt_valid` together with a channel number. The block holds the grant in a two-state machine:

- **ST_IDLE**: no grant is held. The transition *load* (a valid grant naming a non-reserved channel) moves the machine to ST_ARMED.
- **ST_ARMED**: translation is enabled. It has three transitions:
  - *reload*: a new valid grant replaces the held channel and stays in ST_ARMED.
  - *keep*: a claimed access without terminal count, or an unclaimed access, stays in ST_ARMED.
  - *release*: a claimed terminal-count access with no grant in the same cycle returns to ST_IDLE.

Reset forces ST_IDLE. Outputs are registered: the result of an access sampled at one clock edge appears after that edge and lasts one cycle.

Top module: `dma_cycle_xlate`

## Requirements
- R1: After reset, all outputs are 0 and no grant is held.
- R2: A `gnt_valid` pulse with any channel other than 4 arms translation for that channel. Channel 4 is reserved, and a grant naming it changes nothing.
- R3: A strobed access while no grant is held produces neither `cmd_done` nor `cmd_unclaimed`.
- R4: Only the full 32-bit addresses 0x00, 0x04, 0xC0 and 0xC4 are DMA addresses. 0x00 and 0x04 are normal cycles, and 0xC0 and 0xC4 are verify cycles. Address bit 2 is the terminal-count flag, with 1 meaning terminal count, and it appears on `cmd_tc`.
- R5: On a normal address, a PCI read (`io_write`=0) gives `cmd_type` 2'b01 (ISA read) and a PCI write gives 2'b10 (ISA write).
- R6: On a verify address, a PCI read gives `cmd_type` 2'b11 (ISA verify). A PCI write there is unclaimed.
- R7: Under a grant, an access to any non-DMA address raises `cmd_unclaimed` for one cycle, issues no command and keeps the grant.
- R8: `cmd_done` or `cmd_unclaimed` is high for exactly the one cycle after the edge that samples the strobe, and never both at once. While `cmd_done` is 0, `cmd_type`, `cmd_tc` and `cmd_chan` are 0.
- R9: `cmd_chan` equals the granted channel number unchanged.
- R10: A completed terminal-count command releases the grant, so that a later access is ignored. A command without terminal count keeps the grant.
- R11: A grant in the same cycle as an access behaves as follows:
  - While idle, the access is ignored and the grant loads.
  - While armed, the access uses the previously held channel, the new channel is loaded, and the grant survives even a terminal-count access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gnt_valid | input | 1 | One-cycle pulse: a DMA grant is presented |
| gnt_chan | input | 3 | Channel number of the grant |
| io_addr | input | 32 | PCI I/O address of the access |
| io_write | input | 1 | 1 = PCI I/O write, 0 = read |
| io_strobe | input | 1 | One-cycle pulse: an I/O access is presented |
| cmd_done | output | 1 | One-cycle pulse: a DMA command was issued |
| cmd_type | output | 2 | 00 none, 01 read, 10 write, 11 verify |
| cmd_tc | output | 1 | Terminal count of the issued command |
| cmd_chan | output | 3 | Channel of the issued command |
| cmd_unclaimed | output | 1 | One-cycle pulse: access under grant was not a DMA cycle |

## Verification
For every channel, the bench sweeps all 256 low addresses in both read and write. This tells the four DMA addresses apart from every near miss, and verify reads apart from verify writes. Grants are interleaved in a varying pattern, so some accesses arrive unarmed, some after a terminal-count release, and some in the same cycle as a new grant. This separates the held-channel path from the newly granted one. Accesses with high address bits set distinguish full-address matching from low-byte matching. The reserved channel shows whether a grant was wrongly accepted.

// File: rtl/dcx_pkg.sv
package dcx_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_READ   = 2'b01,
        CMD_WRITE  = 2'b10,
        CMD_VERIFY = 2'b11
    } dma_cmd_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } gnt_state_e;

    typedef struct packed {
        logic     claimed;
        dma_cmd_e cmd;
        logic     tc;
    } xlate_s;

endpackage

// File: rtl/dcx_decode.sv
module dcx_decode
    import dcx_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                TC_BIT      = 2,
    parameter logic [ADDR_W-1:0] NORM_BASE   = '0,
    parameter logic [ADDR_W-1:0] VERIFY_BASE = ADDR_W'('hC0)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output xlate_s            res
);

    localparam logic [ADDR_W-1:0] TC_MASK = ADDR_W'(1) << TC_BIT;

    logic [ADDR_W-1:0] base;
    logic              hit_norm;
    logic              hit_verify;

    assign base       = addr & ~TC_MASK;
    assign hit_norm   = (base == NORM_BASE);
    assign hit_verify = (base == VERIFY_BASE);

    always_comb begin
        res         = '0;
        res.cmd     = CMD_NONE;
        res.tc      = addr[TC_BIT];
        if (hit_norm) begin
            res.claimed = 1'b1;
            res.cmd     = is_write ? CMD_WRITE : CMD_READ;
        end else if (hit_verify && !is_write) begin
            res.claimed = 1'b1;
            res.cmd     = CMD_VERIFY;
        end
    end

endmodule

// File: rtl/dcx_grant_fsm.sv
module dcx_grant_fsm
    import dcx_pkg::*;
#(
    parameter int CHAN_W    = 3,
    parameter int RESV_CHAN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_valid,
    input  logic [CHAN_W-1:0] gnt_chan,
    input  logic              acc_hit,
    input  logic              acc_tc,
    output logic              armed,
    output logic [CHAN_W-1:0] held_chan
);

    gnt_state_e state, state_nx;
    logic       gnt_ok;

    assign gnt_ok = gnt_valid && (gnt_chan != CHAN_W'(RESV_CHAN));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (gnt_ok) state_nx = ST_ARMED;               // load
            end
            ST_ARMED: begin
                if (gnt_ok)                 state_nx = ST_ARMED; // reload
                else if (acc_hit && acc_tc) state_nx = ST_IDLE;  // release
                else                        state_nx = ST_ARMED; // keep
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      held_chan <= '0;
        else if (gnt_ok) held_chan <= gnt_chan;
    end

    assign armed = (state == ST_ARMED);

    assert_resv_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && gnt_valid && gnt_chan == CHAN_W'(RESV_CHAN)) |=> (state == ST_IDLE));

    assert_release_tc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && acc_hit && acc_tc && !gnt_valid) |=> !armed);

    assert_hold_chan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !gnt_valid) |=> $stable(held_chan));

endmodule

// File: rtl/dcx_issue.sv
module dcx_issue
    import dcx_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              is_write,
    input  logic              armed,
    input  logic [CHAN_W-1:0] held_chan,
    input  xlate_s            res,
    output logic              done,
    output dma_cmd_e          cmd,
    output logic              tc,
    output logic [CHAN_W-1:0] chan,
    output logic              unclaimed
);

    logic take;
    logic issue;

    assign take  = strobe && armed;
    assign issue = take && res.claimed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            unclaimed <= 1'b0;
            cmd       <= CMD_NONE;
            tc        <= 1'b0;
            chan      <= '0;
        end else begin
            done      <= issue;
            unclaimed <= take && !res.claimed;
            cmd       <= issue ? res.cmd : CMD_NONE;
            tc        <= issue && res.tc;
            chan      <= issue ? held_chan : '0;
        end
    end

    assert_excl_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && unclaimed));

    assert_caused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || unclaimed) |-> $past(strobe && armed));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (cmd == CMD_NONE && !tc && chan == '0));

    assert_verify_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd == CMD_VERIFY) |-> !$past(is_write));

    assert_idle_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !armed) |=> (!done && !unclaimed));

endmodule

// File: rtl/dma_cycle_xlate.sv
module dma_cycle_xlate
    import dcx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CHAN_W    = 3,
    parameter int TC_BIT    = 2,
    parameter int RESV_CHAN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt_valid,
    input  logic [CHAN_W-1:0] gnt_chan,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_write,
    input  logic              io_strobe,
    output logic              cmd_done,
    output logic [1:0]        cmd_type,
    output logic              cmd_tc,
    output logic [CHAN_W-1:0] cmd_chan,
    output logic              cmd_unclaimed
);

    xlate_s            dec;
    logic              armed;
    logic [CHAN_W-1:0] held_chan;
    logic              acc_hit;
    dma_cmd_e          cmd_e;

    dcx_decode #(
        .ADDR_W (ADDR_W),
        .TC_BIT (TC_BIT)
    ) u_decode (
        .addr     (io_addr),
        .is_write (io_write),
        .res      (dec)
    );

    assign acc_hit = io_strobe && armed && dec.claimed;

    dcx_grant_fsm #(
        .CHAN_W    (CHAN_W),
        .RESV_CHAN (RESV_CHAN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt_valid (gnt_valid),
        .gnt_chan  (gnt_chan),
        .acc_hit   (acc_hit),
        .acc_tc    (dec.tc),
        .armed     (armed),
        .held_chan (held_chan)
    );

    dcx_issue #(
        .CHAN_W (CHAN_W)
    ) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (io_strobe),
        .is_write  (io_write),
        .armed     (armed),
        .held_chan (held_chan),
        .res       (dec),
        .done      (cmd_done),
        .cmd       (cmd_e),
        .tc        (cmd_tc),
        .chan      (cmd_chan),
        .unclaimed (cmd_unclaimed)
    );

    assign cmd_type = cmd_e;

    assert_resv_chan_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (cmd_chan != CHAN_W'(RESV_CHAN)));

    assert_write_not_verify_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(io_strobe && io_write) |-> (cmd_type != 2'b11));

endmodule

// File: tb/dma_cycle_xlate_bench.sv
`timescale 1ns/1ps
module dma_cycle_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        gnt_valid;
    logic [2:0]  gnt_chan;
    logic [31:0] io_addr;
    logic        io_write;
    logic        io_strobe;
    logic        cmd_done;
    logic [1:0]  cmd_type;
    logic        cmd_tc;
    logic [2:0]  cmd_chan;
    logic        cmd_unclaimed;

    int total = 0;
    int bad   = 0;

    bit       m_armed = 0;
    bit [2:0] m_chan  = 0;

    always #2 clk = ~clk;

    dma_cycle_xlate u_dma_cycle_xlate (
        .clk           (clk),
        .rst_n         (rst_n),
        .gnt_valid     (gnt_valid),
        .gnt_chan      (gnt_chan),
        .io_addr       (io_addr),
        .io_write      (io_write),
        .io_strobe     (io_strobe),
        .cmd_done      (cmd_done),
        .cmd_type      (cmd_type),
        .cmd_tc        (cmd_tc),
        .cmd_chan      (cmd_chan),
        .cmd_unclaimed (cmd_unclaimed)
    );

    task automatic chk(string tag, bit ed, bit [1:0] et, bit etc, bit [2:0] ech, bit eu);
        total++;
        if ({cmd_done, cmd_type, cmd_tc, cmd_chan, cmd_unclaimed} !== {ed, et, etc, ech, eu}) begin
            bad++;
            $display("FAIL %s: got done=%0b type=%0d tc=%0b chan=%0d unc=%0b, expected done=%0b type=%0d tc=%0b chan=%0d unc=%0b",
                     tag, cmd_done, cmd_type, cmd_tc, cmd_chan, cmd_unclaimed, ed, et, etc, ech, eu);
        end
    endtask

    // One cycle of stimulus, model update and check of the registered result.
    task automatic step(bit gv, bit [2:0] gc, bit st, bit [31:0] ad, bit w, string tag);
        bit       ed = 0;
        bit [1:0] et = 0;
        bit       etc = 0;
        bit [2:0] ech = 0;
        bit       eu = 0;
        bit       norm, ver, claimed;
        bit       rel = 0;
        norm    = (ad == 32'h0) || (ad == 32'h4);
        ver     = (ad == 32'hC0) || (ad == 32'hC4);
        claimed = norm || (ver && !w);
        if (st && m_armed) begin
            if (claimed) begin
                ed  = 1;
                et  = norm ? (w ? 2'b10 : 2'b01) : 2'b11;
                etc = ad[2];
                ech = m_chan;
                rel = ad[2];
            end else begin
                eu = 1;
            end
        end
        @(negedge clk);
        gnt_valid = gv; gnt_chan = gc; io_strobe = st; io_addr = ad; io_write = w;
        @(posedge clk);
        #1;
        chk(tag, ed, et, etc, ech, eu);
        if (gv && gc != 3'd4) begin
            m_armed = 1; m_chan = gc;
        end else if (rel) begin
            m_armed = 0;
        end
    endtask

    function automatic string tag_of(bit armed, bit [31:0] ad, bit w);
        if (!armed) return "R3 R10";
        if (ad == 32'h0 || ad == 32'h4) return "R4 R5 R9 R10";
        if (ad == 32'hC0 || ad == 32'hC4) return w ? "R6 R7" : "R4 R6 R9 R10";
        return "R7 R4";
    endfunction

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; gnt_valid = 0; gnt_chan = 0; io_addr = 0; io_write = 0; io_strobe = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1;
        // R1 / R3: no grant after reset, access ignored
        step(0, 0, 1, 32'h0, 0, "R1 R3 no grant");
        step(0, 0, 0, 32'h0, 0, "R8 idle");
        // R2: reserved channel grant ignored
        step(1, 3'd4, 0, 0, 0, "R2 resv grant");
        step(0, 0, 1, 32'h4, 1, "R2 after resv");
        // R11: grant same cycle as access while idle
        step(1, 3'd3, 1, 32'h0, 0, "R11 idle simul");
        step(0, 0, 1, 32'h0, 1, "R11 loaded R5");
        // R11: armed, new grant with TC access keeps grant, old chan used
        step(1, 3'd6, 1, 32'h4, 0, "R11 armed simul");
        step(0, 0, 1, 32'hC0, 0, "R11 new chan R6");
        step(0, 0, 0, 32'h0, 0, "R8 pulse end");
        // R4: high address bits set must not match
        step(0, 0, 1, 32'h100, 0, "R4 high bit");
        step(0, 0, 1, 32'h8000_00C4, 0, "R4 high bit verify");
        step(0, 0, 1, 32'h8, 0, "R4 near miss");
        // R10: TC verify releases, following access ignored
        step(0, 0, 1, 32'hC4, 0, "R10 tc verify");
        step(0, 0, 1, 32'h0, 0, "R10 released");

        for (int ch = 0; ch < 8; ch++) begin
            for (int a = 0; a < 256; a++) begin
                for (int w = 0; w < 2; w++) begin
                    bit g = ((a ^ w ^ ch) & 3) != 0;
                    if (a % 7 == 0) begin
                        step(1, 3'((ch + 1) % 8), 1, 32'(a), 1'(w),
                             m_armed ? "R11 R9 armed simul" : "R11 R3 idle simul");
                    end else begin
                        if (g) step(1, 3'(ch), 0, 0, 0, "R2 grant");
                        step(0, 0, 1, 32'(a), 1'(w), tag_of(m_armed, 32'(a), 1'(w)));
                    end
                    if (a % 5 == 0) step(0, 0, 0, 0, 0, "R8 one cycle");
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule